// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Tagging

This block receives asynchronous serial characters in a multidrop (wake-up) format. In this format the slot after the data bits carries an address/data tag instead of a parity bit. The serial line is sampled on a 16x sample enable that comes from outside the block. Each completed character goes into a three-entry holding queue. An entry holds the data bits and a status byte that records the tag, framing error, break and overrun conditions.

An enable input selects how tagged characters are filtered. With the enable low, the receiver is asleep: only address-tagged characters are queued, and each one raises the ready output so a host can wake up. Data-tagged characters are dropped. With the enable high, every character is queued whatever its tag. No parity is computed or checked. A host reads the oldest entry combinationally and removes it with a one-cycle pop strobe.

Top module: `mdrx_top`

## Requirements
- R1: After synchronous reset, rx_ready is 0 and rd_data and rd_status are both 0.
- R2: The idle line is high. A low level starts a frame only if the line is still low at mid-bit of the start bit. A shorter low pulse produces no character.
- R3: len_sel selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first. Unused upper bits of rd_data read as 0.
- R4: The bit after the data bits is the tag (1 = address, 0 = data). It is stored in rd_status bit 5. No parity check is made on it.
- R5: With rx_enable low, an address-tagged character is queued and raises rx_ready. A data-tagged character is discarded and leaves the queue unchanged.
- R6: With rx_enable high, every completed character is queued regardless of its tag.
- R7: A zero stop bit sets rd_status bit 6. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: A frame whose data, tag and stop bits are all zero is a break. It sets rd_status bits 7 and 6 with zero data. A line held low for longer queues only one entry.
- R9: The queue holds 3 entries in arrival order. rx_ready is high exactly when the queue is not empty. A pop while the queue is empty has no effect.
- R10: If an accepted character completes while the queue is full and no pop occurs in that cycle, the character is discarded and bit 4 of the newest stored entry's status is set.
- R11: While the queue is empty, rd_data and rd_status read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial input, idle high |
| rx_enable | input | 1 | 1 = keep all characters; 0 = keep only address-tagged characters |
| len_sel | input | 2 | Data length code (0..3 → 5..8 bits) |
| pop | input | 1 | Remove the oldest queue entry |
| rx_ready | output | 1 | Queue not empty |
| rd_data | output | 8 | Data bits of the oldest entry |
| rd_status | output | 8 | Status of the oldest entry: bit7 break, bit6 framing, bit5 tag, bit4 overrun |

## Verification
The assertions assume that sample_en is a single-cycle strobe. They also assume that rxd and len_sel stay steady over a full bit time and over a whole frame, and that pop is not raised in the same cycle a character completes. The stimulus holds every bit level for sixteen strobes. It changes len_sel and rx_enable only between frames, and it pops only after a frame and its idle gap are complete, so a queue write never meets a pop. Random frames cover both tag values, all four lengths, both enable states and occasional zero stop bits. Directed cases cover a long break, a short glitch and queue overflow.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;
    localparam int CHAR_MAX = 8;
    localparam int ST_OVR   = 4;
    localparam int ST_TAG   = 5;
    localparam int ST_FERR  = 6;
    localparam int ST_BRK   = 7;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_TAG, S_STOP, S_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                tag;
        logic                ferr;
        logic                brk;
    } rx_char_t;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic [7:0]          status;
    } rx_entry_t;

    function automatic logic [7:0] pack_status(rx_char_t c);
        logic [7:0] s;
        s = '0;
        s[ST_TAG]  = c.tag;
        s[ST_FERR] = c.ferr;
        s[ST_BRK]  = c.brk;
        return s;
    endfunction

    function automatic logic [2:0] last_index(logic [1:0] len);
        return {1'b0, len} + 3'd4;
    endfunction
endpackage

// File: rtl/mdrx_frame.sv
module mdrx_frame
    import mdrx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx,
    input  logic [1:0] len_sel,
    output logic     out_valid,
    output rx_char_t out_char
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [2:0]          bidx;
    logic [CHAR_MAX-1:0] shreg;
    logic                tagr;
    logic                bit_due;

    assign bit_due = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            tagr      <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: if (!rx) begin
                        state <= S_START;
                        cnt   <= '0;
                    end
                    S_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rx) begin
                                state <= S_DATA;
                                bidx  <= '0;
                                shreg <= '0;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (bit_due) begin
                            cnt         <= '0;
                            shreg[bidx] <= rx;
                            if (bidx == last_index(len_sel)) state <= S_TAG;
                            else bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_TAG: begin
                        if (bit_due) begin
                            cnt   <= '0;
                            tagr  <= rx;
                            state <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (bit_due) begin
                            cnt            <= '0;
                            out_valid      <= 1'b1;
                            out_char.data  <= shreg;
                            out_char.tag   <= tagr;
                            out_char.ferr  <= !rx;
                            out_char.brk   <= !rx && !tagr && (shreg == '0);
                            state          <= rx ? S_IDLE : S_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_HOLD: if (rx) state <= S_IDLE;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8
    brk_ferr_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_char.brk) |-> (out_char.ferr && out_char.data == '0));

    // R7
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_char.ferr) |-> (state == S_HOLD));
endmodule

// File: rtl/mdrx_fifo.sv
module mdrx_fifo
    import mdrx_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t push_ent,
    input  logic      pop,
    input  logic      mark_ovr,
    output rx_entry_t head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0]   PMAX = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] CFULL = CNTW'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          do_pop, do_push;

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PMAX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_prev(logic [PW-1:0] p);
        return (p == '0) ? PMAX : p - 1'b1;
    endfunction

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count != CFULL) || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_ent;
                wr_ptr      <= ptr_next(wr_ptr);
            end else if (mark_ovr) begin
                mem[ptr_prev(wr_ptr)].status[ST_OVR] <= 1'b1;
            end
            if (do_pop) rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && pop && !push) |=> (count == '0));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count == CFULL) |=> (count == CFULL));
endmodule

// File: rtl/mdrx_top.sv
module mdrx_top
    import mdrx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_en,
    input  logic       rxd,
    input  logic       rx_enable,
    input  logic [1:0] len_sel,
    input  logic       pop,
    output logic       rx_ready,
    output logic [7:0] rd_data,
    output logic [7:0] rd_status
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] CFULL = CNTW'(DEPTH);

    logic [1:0]      sync;
    logic            frm_valid;
    rx_char_t        frm_char;
    rx_entry_t       ent, head;
    logic [CNTW-1:0] fcount;
    logic            accept, full, push, ovr;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end

    mdrx_frame #(.OSR(OSR)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (sample_en),
        .rx       (sync[1]),
        .len_sel  (len_sel),
        .out_valid(frm_valid),
        .out_char (frm_char)
    );

    assign accept     = frm_valid && (rx_enable || frm_char.tag);
    assign full       = (fcount == CFULL);
    assign push       = accept && (!full || pop);
    assign ovr        = accept && full && !pop;
    assign ent.data   = frm_char.data;
    assign ent.status = pack_status(frm_char);

    mdrx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .push_ent(ent),
        .pop     (pop),
        .mark_ovr(ovr),
        .head    (head),
        .count   (fcount)
    );

    assign rx_ready  = (fcount != '0);
    assign rd_data   = rx_ready ? head.data   : '0;
    assign rd_status = rx_ready ? head.status : '0;

    // R5
    drop_data_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !rx_enable && !frm_char.tag && !pop) |=> $stable(fcount));

    // R6
    keep_all_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && rx_enable && !full && !pop) |=> (fcount == $past(fcount) + 1'b1));

    // R10
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && full && !pop) |=> (fcount == CFULL && rx_ready));
endmodule

// File: tb/mdrx_top_test.sv
module mdrx_top_test;
    localparam int BITCLK = 64;

    logic       clk = 0;
    logic       rst = 1;
    logic       sample_en = 0;
    logic       rxd = 1;
    logic       rx_enable = 0;
    logic [1:0] len_sel = 2'd3;
    logic       pop = 0;
    logic       rx_ready;
    logic [7:0] rd_data, rd_status;
    logic [1:0] tdiv = 0;

    int checks = 0;
    int fails  = 0;

    logic [7:0] qd [3];
    logic [7:0] qs [3];
    int         mcnt = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv      <= tdiv + 1'b1;
        sample_en <= (tdiv == 2'd3);
    end

    mdrx_top uut (
        .clk(clk), .rst(rst), .sample_en(sample_en), .rxd(rxd),
        .rx_enable(rx_enable), .len_sel(len_sel), .pop(pop),
        .rx_ready(rx_ready), .rd_data(rd_data), .rd_status(rd_status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic v, input int n);
        rxd = v;
        repeat (n * BITCLK) @(negedge clk);
    endtask

    function automatic int nbits(input logic [1:0] l);
        return int'(l) + 5;
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic tag, input logic stopb);
        send_bits(1'b0, 1);
        for (int i = 0; i < nbits(len_sel); i++) send_bits(d[i], 1);
        send_bits(tag, 1);
        send_bits(stopb, 1);
        send_bits(1'b1, 2);
    endtask

    task automatic model_char(input logic [7:0] d, input logic tag, input logic ferr, input logic brk);
        logic [7:0] s;
        s = {brk, ferr, tag, 5'b0};
        if (rx_enable || tag) begin
            if (mcnt == 3) qs[2] = qs[2] | 8'h10;
            else begin
                qd[mcnt] = d;
                qs[mcnt] = s;
                mcnt++;
            end
        end
    endtask

    task automatic frame_and_model(input logic [7:0] draw, input logic tag, input logic stopb);
        logic [7:0] d;
        d = draw & 8'((1 << nbits(len_sel)) - 1);
        send_frame(d, tag, stopb);
        model_char(d, tag, !stopb, !stopb && !tag && d == 0);
    endtask

    task automatic pop_check(input string tagname);
        chk(rx_ready == (mcnt != 0), {"R9 ready ", tagname}, int'(rx_ready), int'(mcnt != 0));
        if (mcnt > 0) begin
            chk(rd_data == qd[0], {"R3 data ", tagname}, int'(rd_data), int'(qd[0]));
            chk(rd_status == qs[0], {"R4 status ", tagname}, int'(rd_status), int'(qs[0]));
            pop = 1;
            @(negedge clk);
            pop = 0;
            qd[0] = qd[1]; qs[0] = qs[1];
            qd[1] = qd[2]; qs[1] = qs[2];
            mcnt--;
        end else begin
            chk(rd_data == 0 && rd_status == 0, {"R11 empty ", tagname},
                int'({rd_data, rd_status}), 0);
            pop = 1;
            @(negedge clk);
            pop = 0;
            chk(rx_ready == 0, {"R9 pop empty ", tagname}, int'(rx_ready), 0);
        end
        @(negedge clk);
    endtask

    task automatic drain(input string tagname);
        while (mcnt > 0) pop_check(tagname);
        pop_check(tagname);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(rx_ready == 0, "R1 ready", int'(rx_ready), 0);
        chk(rd_data == 0 && rd_status == 0, "R1 outputs", int'({rd_data, rd_status}), 0);
        send_bits(1'b1, 2);

        // R5 asleep: data dropped, address kept
        rx_enable = 0; len_sel = 2'd3;
        frame_and_model(8'hA5, 1'b0, 1'b1);
        chk(rx_ready == 0, "R5 data dropped", int'(rx_ready), 0);
        frame_and_model(8'h3C, 1'b1, 1'b1);
        chk(rx_ready == 1, "R5 address wakes", int'(rx_ready), 1);
        drain("R5");

        // R3 R6 each length, both tags kept when enabled
        rx_enable = 1;
        for (int l = 0; l < 4; l++) begin
            len_sel = 2'(l);
            frame_and_model(8'hFF, 1'(l % 2), 1'b1);
            pop_check("R3 length");
        end

        // R7 framing error
        len_sel = 2'd3;
        frame_and_model(8'h55, 1'b1, 1'b0);
        pop_check("R7 framing");

        // R8 long break gives a single entry
        send_bits(1'b0, 25);
        send_bits(1'b1, 3);
        model_char(8'h00, 1'b0, 1'b1, 1'b1);
        chk(mcnt == 1, "R8 model", mcnt, 1);
        pop_check("R8 break");
        chk(rx_ready == 0, "R8 single entry", int'(rx_ready), 0);

        // R2 short glitch
        rxd = 0;
        repeat (12) @(negedge clk);
        send_bits(1'b1, 2);
        chk(rx_ready == 0, "R2 glitch", int'(rx_ready), 0);

        // R10 overrun on fourth character
        for (int i = 0; i < 4; i++) frame_and_model(8'(8'h11 * (i + 1)), 1'b0, 1'b1);
        chk(mcnt == 3, "R10 model", mcnt, 3);
        drain("R10 overrun");

        // random mix
        for (int n = 0; n < 110; n++) begin
            rx_enable = 1'($urandom % 2);
            len_sel   = 2'($urandom % 4);
            frame_and_model(8'($urandom), 1'($urandom % 2), ($urandom % 8) != 0);
            for (int p = 0; p < int'($urandom % 3); p++) pop_check("random");
        end
        drain("final");
        finish_run();
    end
endmodule